// File: doc/BRIEF.md
# Paged Memory Address Translator

This block turns a 16-bit processor address into a target code and a physical address. Translation has two stages. The first stage is a remap window. When the window is enabled, addresses 0x7C00 to 0x7FFF are shifted by a programmable offset into extended RAM. The second stage is a page map of 128 entries. Each entry is selected by a segment register together with the top four address bits, and it replaces the 4 KB page with a bank number.

Some bank values send the access somewhere other than a plain page:
- Bank 0x30 to 0x3E sends it back into the standard 64 KB map.
- Bank 0x3F sends it to a small shadow RAM, a boot ROM, or the fixed I/O region.
- Other values reach an extended RAM page, or a null target when that page is not fitted.

Any address that is not remapped passes through unchanged. A separate fixed decoder handles it.

Lookups travel as a valid/ready stream with a single registered stage. Software programs the offset, the segment and the map entries through a plain write port. A write takes effect for every lookup accepted on a later clock edge.

Top module: `page_xlate`

## Requirements
- R1: After reset, map entry i holds bank 0x30 + (i mod 16), the segment and window offset are 0, rsp_valid is low and req_ready is high.
- R2: A lookup is accepted on a rising edge where req_valid and req_ready are both high. Its result appears with rsp_valid on the next cycle. While rsp_valid is high and rsp_ready is low, the result stays unchanged and req_ready is low. req_ready is high whenever rsp_valid is low or rsp_ready is high.
- R3: cfg_we with cfg_sel selects what is written: 0 writes the window offset (8 bits), 1 writes the segment (only the low 4 bits of cfg_wdata are kept), and 2 writes map entry cfg_idx (only the low 7 bits are kept as the bank). cfg_sel 3 changes nothing.
- R4: When req_win_en is set and the address is in 0x7C00..0x7FFF, the target is EXT (code 1) and phys = 0x20000 + ((offset*256 + addr) mod 65536). This holds whatever req_page_en is.
- R5: When req_page_en is clear, or the address is 0xFC00 or above, and R4 does not apply, the target is STD (code 0) and phys equals the address.
- R6: The map index is {segment, addr[15:12]} truncated to 7 bits, so segment bit 3 takes no part.
- R7: Bank 0x30..0x3E gives STD with phys = {bank[3:0], addr[11:0]}.
- R8: Bank 0x3F uses the page offset o = addr[11:0]:
  - o in 0xC00..0xDFF gives SHADOW (code 2) with phys = o - 0xC00.
  - o of 0xE00 or more gives BOOT (code 3) with phys = o - 0xE00.
  - Any other o gives STD with phys = 0xF000 | o.
- R9: A bank below 0x30 whose bits [6:4] are below EXT_PAGES (capped at 3) gives EXT with phys = {bank[5:0], o}, provided ext_present is high. Otherwise, and for every bank from 0x40 upward, the result is NULL (code 4) with phys 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 offset, 1 segment, 2 map entry |
| cfg_idx | input | 7 | Map entry index for cfg_sel 2 |
| cfg_wdata | input | 8 | Write data |
| ext_present | input | 1 | Extended RAM fitted |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_addr | input | 16 | Processor address |
| req_win_en | input | 1 | Remap window enabled for this lookup |
| req_page_en | input | 1 | Page map enabled for this lookup |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_target | output | 3 | Target code: 0 STD, 1 EXT, 2 SHADOW, 3 BOOT, 4 NULL |
| rsp_phys | output | 18 | Physical address within the target |

## Verification
A lookup taken on one rising edge shows its result one cycle later. The bench drives requests at falling edges and compares rsp_target and rsp_phys at the next falling edge, once rsp_valid has risen.

A register write is issued on its own edge before the lookup that depends on it. This keeps the write's one-cycle latency out of the comparison.

For back-pressure, the bench holds rsp_ready low for several cycles and checks on each of them that the earlier result is held and the pending request is refused. It then checks that the pending request lands one cycle after rsp_ready returns.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  localparam int ADDR_W = 16;
  localparam int PHYS_W = 18;
  localparam int SEG_W  = 4;
  localparam int PG_W   = 4;
  localparam int OFF_W  = ADDR_W - PG_W;
  localparam int BANK_W = 7;
  localparam int IDX_W  = 7;
  localparam int MAP_N  = 1 << IDX_W;

  localparam logic [ADDR_W-1:0] WIN_LO   = 16'h7C00;
  localparam logic [ADDR_W-1:0] WIN_HI   = 16'h7FFF;
  localparam logic [ADDR_W-1:0] PAGE_TOP = 16'hFC00;
  localparam logic [OFF_W-1:0]  SHD_LO   = 12'hC00;
  localparam logic [OFF_W-1:0]  BOOT_LO  = 12'hE00;
  localparam logic [BANK_W-1:0] SYS_BANK = 7'h3F;

  typedef enum logic [2:0] {
    TGT_STD    = 3'd0,
    TGT_EXT    = 3'd1,
    TGT_SHADOW = 3'd2,
    TGT_BOOT   = 3'd3,
    TGT_NULL   = 3'd4
  } tgt_e;

  typedef enum logic [1:0] {
    SEL_WOFS = 2'd0,
    SEL_SEG  = 2'd1,
    SEL_MAP  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [PHYS_W-1:0] phys;
  } xres_t;
endpackage

// File: rtl/page_xlate_regs.sv
module page_xlate_regs
  import page_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        win_ofs,
  output logic [SEG_W-1:0]  seg,
  output logic [BANK_W-1:0] rd_bank
);
  logic [BANK_W-1:0] map_q [MAP_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_ofs <= '0;
      seg     <= '0;
    end else if (we) begin
      if (cfg_sel_e'(sel) == SEL_WOFS) win_ofs <= wdata;
      if (cfg_sel_e'(sel) == SEL_SEG)  seg     <= wdata[SEG_W-1:0];
    end
  end

  // one flop group per entry; reset value maps each page onto itself
  for (genvar g = 0; g < MAP_N; g++) begin : g_entry
    localparam logic [BANK_W-1:0] RST_BANK = BANK_W'(8'h30 + (g % (1 << PG_W)));
    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[g] <= RST_BANK;
      else if (we && cfg_sel_e'(sel) == SEL_MAP && idx == IDX_W'(g))
        map_q[g] <= wdata[BANK_W-1:0];
    end
  end

  assign rd_bank = map_q[rd_idx];
endmodule

// File: rtl/page_xlate_core.sv
module page_xlate_core
  import page_xlate_pkg::*;
#(
  parameter int EXT_PAGES = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              win_en,
  input  logic              page_en,
  input  logic              ext_present,
  input  logic [7:0]        win_ofs,
  input  logic [BANK_W-1:0] bank,
  output xres_t             res
);
  localparam int EXT_LIM = (EXT_PAGES > 3) ? 3 : EXT_PAGES;

  logic [OFF_W-1:0]  off;
  logic [2:0]        major;
  logic [ADDR_W-1:0] win_sum;
  logic              in_win;

  assign off     = addr[OFF_W-1:0];
  assign major   = bank[BANK_W-1:4];
  assign win_sum = {win_ofs, 8'h00} + addr;
  assign in_win  = win_en && addr >= WIN_LO && addr <= WIN_HI;

  always_comb begin
    res.tgt  = TGT_STD;
    res.phys = PHYS_W'(addr);
    if (in_win) begin
      res.tgt  = TGT_EXT;
      res.phys = {2'b10, win_sum};
    end else if (page_en && addr < PAGE_TOP) begin
      if (major == 3'd3 && bank != SYS_BANK) begin
        res.phys = PHYS_W'({bank[3:0], off});
      end else if (bank == SYS_BANK) begin
        if (off >= SHD_LO && off < BOOT_LO) begin
          res.tgt  = TGT_SHADOW;
          res.phys = PHYS_W'(off - SHD_LO);
        end else if (off >= BOOT_LO) begin
          res.tgt  = TGT_BOOT;
          res.phys = PHYS_W'(off - BOOT_LO);
        end else begin
          res.phys = PHYS_W'({4'hF, off});
        end
      end else if (ext_present && int'(major) < EXT_LIM) begin
        res.tgt  = TGT_EXT;
        res.phys = {bank[5:0], off};
      end else begin
        res.tgt  = TGT_NULL;
        res.phys = '0;
      end
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int EXT_PAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [6:0]  cfg_idx,
  input  logic [7:0]  cfg_wdata,
  input  logic        ext_present,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  input  logic        req_win_en,
  input  logic        req_page_en,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [2:0]  rsp_target,
  output logic [17:0] rsp_phys
);
  logic [7:0]        win_ofs;
  logic [SEG_W-1:0]  seg;
  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0]  map_idx;
  xres_t             res_d;
  xres_t             res_q;

  assign map_idx = IDX_W'({seg, req_addr[ADDR_W-1 -: PG_W]});

  page_xlate_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .idx     (cfg_idx),
    .wdata   (cfg_wdata),
    .rd_idx  (map_idx),
    .win_ofs (win_ofs),
    .seg     (seg),
    .rd_bank (bank)
  );

  page_xlate_core #(.EXT_PAGES(EXT_PAGES)) u_core (
    .addr        (req_addr),
    .win_en      (req_win_en),
    .page_en     (req_page_en),
    .ext_present (ext_present),
    .win_ofs     (win_ofs),
    .bank        (bank),
    .res         (res_d)
  );

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      res_q     <= '{tgt: TGT_NULL, phys: '0};
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) res_q <= res_d;
    end
  end

  assign rsp_target = res_q.tgt;
  assign rsp_phys   = res_q.phys;
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_addr,
  input logic        req_win_en,
  input logic        req_page_en,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [2:0]  rsp_target,
  input logic [17:0] rsp_phys
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_target) && $stable(rsp_phys));

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_win_en && req_addr >= 16'h7C00 && req_addr <= 16'h7FFF
    |=> rsp_target == 3'd1 && rsp_phys[17:16] == 2'b10);

  a_r5_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_page_en && !req_win_en
    |=> rsp_target == 3'd0 && rsp_phys == {2'b00, $past(req_addr)});

  a_r5_high_area: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr >= 16'hFC00
    |=> rsp_target == 3'd0 && rsp_phys == {2'b00, $past(req_addr)});

  a_r8_small_regions: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_target == 3'd2 || rsp_target == 3'd3) |-> rsp_phys < 18'h200);

  a_r9_null_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_target == 3'd4 |-> rsp_phys == '0);
endmodule

bind page_xlate page_xlate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_win_en  (req_win_en),
  .req_page_en (req_page_en),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_target  (rsp_target),
  .rsp_phys    (rsp_phys)
);

// File: tb/test_page_xlate.sv
module test_page_xlate;
  localparam int EXT_PAGES = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [6:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        ext_present = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_win_en = 1'b0;
  logic        req_page_en = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [2:0]  rsp_target;
  logic [17:0] rsp_phys;

  int checks = 0;
  int failures = 0;
  logic [6:0] m_map [128];
  logic [3:0] m_seg;
  logic [7:0] m_ofs;

  always #10 clk = ~clk;

  page_xlate #(.EXT_PAGES(EXT_PAGES)) i_page_xlate (.*);

  task automatic check(input bit ok, input string tag, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] model(input logic [15:0] a, input bit w, input bit p, input bit ex,
                                        output string tag);
    logic [6:0]  b;
    logic [11:0] o;
    logic [15:0] s;
    o = a[11:0];
    b = m_map[{m_seg[2:0], a[15:12]}];
    s = {m_ofs, 8'h00} + a;
    if (w && a >= 16'h7C00 && a <= 16'h7FFF) begin tag = "R4"; return {3'd1, 2'b10, s}; end
    if (!p || a >= 16'hFC00) begin tag = "R5"; return {3'd0, 2'b00, a}; end
    if (b >= 7'h30 && b <= 7'h3E) begin tag = "R7"; return {3'd0, 2'b00, b[3:0], o}; end
    if (b == 7'h3F) begin
      tag = "R8";
      if (o >= 12'hC00 && o < 12'hE00) return {3'd2, 18'(o - 12'hC00)};
      if (o >= 12'hE00) return {3'd3, 18'(o - 12'hE00)};
      return {3'd0, 2'b00, 4'hF, o};
    end
    tag = "R9";
    if (ex && b < 7'h30 && int'(b[6:4]) < EXT_PAGES) return {3'd1, b[5:0], o};
    return {3'd4, 18'h0};
  endfunction

  task automatic cfg(input logic [1:0] s, input logic [6:0] i, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (s)
      2'd0: m_ofs = d;
      2'd1: m_seg = d[3:0];
      2'd2: m_map[i] = d[6:0];
      default: ;
    endcase
  endtask

  task automatic lookup(input logic [15:0] a, input bit w, input bit p, input string extra);
    logic [20:0] e;
    string t;
    @(negedge clk);
    req_addr = a; req_win_en = w; req_page_en = p; req_valid = 1'b1;
    e = model(a, w, p, ext_present, t);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && {rsp_target, rsp_phys} == e, {t, extra}, {rsp_target, rsp_phys}, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [20:0] held;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 128; i++) m_map[i] = 7'(8'h30 + (i % 16));
    m_seg = '0; m_ofs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!rsp_valid && req_ready, "R1 idle after reset", {19'd0, rsp_valid, req_ready}, 21'd1);
    lookup(16'h1234, 0, 1, " R1 identity map");
    lookup(16'hA5A5, 0, 1, " R1 identity map");
    lookup(16'h7C10, 1, 1, " R1 offset zero");
    // R3 segment keeps low 4 bits; R6 bit 3 ignored in index
    cfg(2'd1, 0, 8'hF9);
    check(m_seg == 4'h9, "R3 model segment", {17'd0, m_seg}, 21'h9);
    cfg(2'd2, 7'h12, 8'hB1);
    lookup(16'h2345, 0, 1, " R3 R6 map low 7 bits via seg 9");
    cfg(2'd3, 7'h12, 8'h3F);
    lookup(16'h2345, 0, 1, " R3 sel 3 no effect");
    // R8 boundaries of bank 0x3F
    cfg(2'd2, 7'h13, 8'h3F);
    lookup(16'h3BFF, 0, 1, " boundary BFF");
    lookup(16'h3C00, 0, 1, " boundary C00");
    lookup(16'h3DFF, 0, 1, " boundary DFF");
    lookup(16'h3E00, 0, 1, " boundary E00");
    lookup(16'h3FFF, 0, 1, " boundary FFF");
    // R9 extended pages
    cfg(2'd2, 7'h14, 8'h1A);
    lookup(16'h4010, 0, 1, " page 1 present");
    cfg(2'd2, 7'h14, 8'h2A);
    lookup(16'h4010, 0, 1, " page 2 beyond count");
    cfg(2'd2, 7'h14, 8'h55);
    lookup(16'h4010, 0, 1, " bank 0x55");
    cfg(2'd2, 7'h14, 8'h05);
    ext_present = 1'b0;
    lookup(16'h4010, 0, 1, " ext absent");
    ext_present = 1'b1;
    // R4 window priority and wrap; R5 top area
    cfg(2'd0, 0, 8'hF0);
    cfg(2'd2, 7'h17, 8'h4F);
    lookup(16'h7FFF, 1, 1, " window wrap priority");
    lookup(16'h7BFF, 1, 0, " below window");
    lookup(16'hFC00, 0, 1, " top area");
    cfg(2'd2, 7'h1F, 8'h3F);
    lookup(16'hFFFF, 1, 1, " top area unmapped");
    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    lookup(16'h0123, 0, 0, " R2 first");
    held = {rsp_target, rsp_phys};
    req_addr = 16'h0456; req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && {rsp_target, rsp_phys} == held, "R2 hold",
            {rsp_target, rsp_phys}, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && {rsp_target, rsp_phys} == {3'd0, 18'h0456}, "R2 release",
          {rsp_target, rsp_phys}, {3'd0, 18'h0456});
    @(negedge clk);
    check(!rsp_valid && req_ready, "R2 drain", {19'd0, rsp_valid, req_ready}, 21'd1);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [15:0] a;
      r = int'($urandom_range(0, 9));
      if (r == 0) cfg(2'($urandom_range(0, 3)), 7'($urandom), 8'($urandom));
      else if (r == 1) cfg(2'd2, 7'($urandom), 8'($urandom_range(0, 8'h7F)));
      else begin
        if (r < 4) a = 16'h7C00 + 16'($urandom_range(0, 16'h3FF));
        else if (r == 4) a = 16'hFC00 + 16'($urandom_range(0, 16'h3FF));
        else a = 16'($urandom);
        ext_present = ($urandom_range(0, 7) != 0);
        lookup(a, 1'($urandom), 1'($urandom_range(0, 3) != 0), " random");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule